// File: doc/BRIEF.md
# Chained MSB-First Magnitude Comparator

This block decides whether an unsigned operand `a` is strictly larger than an unsigned operand `b`. It is purely combinational. The comparison is built as a ripple of identical one-bit compare cells, starting at the top bit and working down. Each cell returns a two-bit code made of a result flag and a continue flag. The continue flag is the enable of the cell one position lower, so a cell only takes part when every bit above it matched.

A priority selector scans the codes from the top bit downward. It forwards the result flag of the first cell that did not ask to continue. When every cell matched, nothing decides and the greater-than output stays low. The continue flag leaving bit 0 is also brought out as an equality indication. The operand width is a parameter of at least one. Delay through the chain grows with the width, one cell per bit.

Top module: `mag_chain_cmp`

## Requirements
- R1: `gt` is 1 exactly when `a` is greater than `b` as an unsigned number, and 0 in every other case.
- R2: When `a` equals `b`, `gt` is 0 and `eq` is 1.
- R3: `eq` is 1 only when `a` equals `b`. For any pair that differs, `eq` is 0.
- R4: Each enabled cell produces a code {result, continue}. The codes are {1,0} when its `a` bit is 1 and its `b` bit is 0, {0,0} when its `a` bit is 0 and its `b` bit is 1, and {0,1} when the two bits match. The code {1,1} never occurs. With WIDTH = 1 the code appears directly on `gt` (result) and `eq` (continue).
- R5: The highest differing bit alone decides the outcome. A pair that differs only in the top bit gives `gt` equal to that bit of `a`, whatever the lower bits hold.
- R6: A pair that differs only in bit 0 gives `gt` equal to bit 0 of `a`.
- R7: A cell whose enable is low drives the code {0,0}. Lower bits below a decided position therefore have no effect on `gt`. For example, with WIDTH = 4, `a` = 4'b1000 and `b` = 4'b0111 give `gt` = 1.
- R8: The block works for any WIDTH of 1 or more. It is checked at WIDTH = 1, 4 and 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| gt | output | 1 | High when a > b |
| eq | output | 1 | High when every bit pair matched (continue flag out of bit 0) |

## Verification
The bench goes after three failure modes:
- **Equal operands.** A selector that fails to default to zero after a full run of matching bits would report equal operands as greater.
- **Top-bit-only and bit-0-only differences.** These catch a chain wired in the wrong direction, or a broken hand-off at either end of the chain. Such a design would let a lower bit override the top bit, or would miss a decision made at bit 0.
- **Lower bits that contradict a decided upper bit.** Pairs such as 1000 against 0111 expose a disabled cell that still drives a result, which would flip the answer.

The width-1 instance exposes the raw cell code on the ports, so a wrong code value shows up directly.

// File: rtl/mag_chain_cmp_pkg.sv
package mag_chain_cmp_pkg;

    // Two-bit status emitted by every compare cell.
    typedef struct packed {
        logic res;   // 1: this bit decided a > b
        logic cont;  // 1: bits matched, hand the decision downward
    } cell_code_t;

    localparam cell_code_t CODE_GREATER = '{res: 1'b1, cont: 1'b0};
    localparam cell_code_t CODE_LESS    = '{res: 1'b0, cont: 1'b0};
    localparam cell_code_t CODE_MATCH   = '{res: 1'b0, cont: 1'b1};
    localparam cell_code_t CODE_IDLE    = '{res: 1'b0, cont: 1'b0};

endpackage

// File: rtl/mag_bit_cell.sv
module mag_bit_cell
    import mag_chain_cmp_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       enable,
    output cell_code_t code
);

    always_comb begin
        if (!enable) begin
            code = CODE_IDLE;
        end else if (a_bit && !b_bit) begin
            code = CODE_GREATER;
        end else if (!a_bit && b_bit) begin
            code = CODE_LESS;
        end else begin
            code = CODE_MATCH;
        end
    end

endmodule

// File: rtl/mag_cell_chain.sv
module mag_cell_chain
    import mag_chain_cmp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] res_vec,
    output logic [WIDTH-1:0] cont_vec
);

    // enable of each cell: the top cell always runs, the rest follow the cell above
    logic [WIDTH-1:0] enable_vec;

    genvar g;
    generate
        for (g = WIDTH - 1; g >= 0; g--) begin : g_cell
            cell_code_t code;

            if (g == WIDTH - 1) begin : g_top
                assign enable_vec[g] = 1'b1;
            end else begin : g_lower
                assign enable_vec[g] = cont_vec[g+1];
            end

            mag_bit_cell u_cell (
                .a_bit  (a[g]),
                .b_bit  (b[g]),
                .enable (enable_vec[g]),
                .code   (code)
            );

            assign res_vec[g]  = code.res;
            assign cont_vec[g] = code.cont;
        end
    endgenerate

endmodule

// File: rtl/mag_first_select.sv
module mag_first_select #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] res_vec,
    input  logic [WIDTH-1:0] cont_vec,
    output logic             gt,
    output logic             eq
);

    always_comb begin
        logic found;
        found = 1'b0;
        gt    = 1'b0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (!found && !cont_vec[i]) begin
                gt    = res_vec[i];
                found = 1'b1;
            end
        end
    end

    assign eq = cont_vec[0];

endmodule

// File: rtl/mag_chain_cmp.sv
module mag_chain_cmp #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             gt,
    output logic             eq
);

    logic [WIDTH-1:0] res_vec;
    logic [WIDTH-1:0] cont_vec;

    mag_cell_chain #(.WIDTH(WIDTH)) u_chain (
        .a        (a),
        .b        (b),
        .res_vec  (res_vec),
        .cont_vec (cont_vec)
    );

    mag_first_select #(.WIDTH(WIDTH)) u_select (
        .res_vec  (res_vec),
        .cont_vec (cont_vec),
        .gt       (gt),
        .eq       (eq)
    );

endmodule

// File: rtl/mag_chain_cmp_chk.sv
module mag_chain_cmp_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             gt,
    input logic             eq,
    input logic [WIDTH-1:0] res_vec,
    input logic [WIDTH-1:0] cont_vec
);

    always_comb begin
        if (!$isunknown({a, b})) begin
            assert_gt_matches_R1: assert (gt == (a > b));
            assert_eq_matches_R3: assert (eq == (a == b));
            if (a == b) begin
                assert_equal_gives_zero_R2: assert (!gt && eq);
            end
            for (int i = 0; i < WIDTH; i++) begin
                assert_no_code_11_R4: assert (!(res_vec[i] && cont_vec[i]));
            end
            assert_top_cell_code_R5: assert (
                res_vec[WIDTH-1] == (a[WIDTH-1] & ~b[WIDTH-1]) &&
                cont_vec[WIDTH-1] == (a[WIDTH-1] == b[WIDTH-1]));
            for (int i = 0; i < WIDTH - 1; i++) begin
                if (!cont_vec[i+1]) begin
                    assert_idle_cell_quiet_R7: assert (!res_vec[i] && !cont_vec[i]);
                end
            end
        end
    end

endmodule

bind mag_chain_cmp mag_chain_cmp_chk #(.WIDTH(WIDTH)) u_chk (
    .a        (a),
    .b        (b),
    .gt       (gt),
    .eq       (eq),
    .res_vec  (res_vec),
    .cont_vec (cont_vec)
);

// File: tb/mag_chain_cmp_bench.sv
module mag_chain_cmp_bench;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [3:0]  a4, b4;
    logic [15:0] a16, b16;
    logic        a1, b1;
    logic        gt4, eq4, gt16, eq16, gt1, eq1;

    mag_chain_cmp #(.WIDTH(4)) u_mag_chain_cmp (
        .a(a4), .b(b4), .gt(gt4), .eq(eq4));
    mag_chain_cmp #(.WIDTH(16)) u_w16 (
        .a(a16), .b(b16), .gt(gt16), .eq(eq16));
    mag_chain_cmp #(.WIDTH(1)) u_w1 (
        .a(a1), .b(b1), .gt(gt1), .eq(eq1));

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic apply4(input logic [3:0] x, input logic [3:0] y, input string tag);
        @(negedge clk);
        a4 = x; b4 = y;
        #1;
        check({tag, " gt4"}, gt4, (x > y) ? 1'b1 : 1'b0);
        check({tag, " eq4"}, eq4, (x == y) ? 1'b1 : 1'b0);
    endtask

    task automatic apply16(input logic [15:0] x, input logic [15:0] y, input string tag);
        @(negedge clk);
        a16 = x; b16 = y;
        #1;
        check({tag, " gt16"}, gt16, (x > y) ? 1'b1 : 1'b0);
        check({tag, " eq16"}, eq16, (x == y) ? 1'b1 : 1'b0);
    endtask

    initial begin
        a4 = '0; b4 = '0; a16 = '0; b16 = '0; a1 = 1'b0; b1 = 1'b0;
        @(negedge clk);
        #1;
        check("R2 reset-state zero operands gt4", gt4, 1'b0);
        check("R2 reset-state zero operands eq4", eq4, 1'b1);

        // R4 / R8: width-1 instance shows the cell code on {gt, eq}
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            a1 = k[1]; b1 = k[0];
            #1;
            check("R4 cell result", gt1, (k[1] & ~k[0]) ? 1'b1 : 1'b0);
            check("R4 cell continue", eq1, (k[1] == k[0]) ? 1'b1 : 1'b0);
        end

        // R1 / R2 / R3: exhaustive sweep at width 4
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                apply4(x[3:0], y[3:0], "R1 R3 sweep4");
            end
        end

        // R7: lower bits contradict the decided upper bit
        apply4(4'b1000, 4'b0111, "R7 upper decides");
        apply4(4'b0111, 4'b1000, "R7 upper decides rev");
        apply4(4'b1011, 4'b1001, "R7 mid decides");

        // R5 / R6 / R2 at width 16
        for (int n = 0; n < 400; n++) begin
            logic [15:0] v;
            v = 16'($urandom);
            apply16(v, v, "R2 equal16");
            apply16(v | 16'h8000, v & 16'h7FFF, "R5 msb-only high");
            apply16(v & 16'h7FFF, v | 16'h8000, "R5 msb-only low");
            apply16(v | 16'h0001, v & 16'hFFFE, "R6 lsb-only high");
            apply16(v & 16'hFFFE, v | 16'h0001, "R6 lsb-only low");
        end
        for (int n = 0; n < 2000; n++) begin
            apply16(16'($urandom), 16'($urandom), "R1 R8 random16");
        end
        apply16(16'hFFFF, 16'h0000, "R1 extreme");
        apply16(16'h0000, 16'hFFFF, "R1 extreme rev");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule